// File: doc/BRIEF.md
# Read-Only Instruction Cache Bridge

This block sits between a processor's instruction-fetch port and an external memory controller. The processor side is a memory-mapped read-only slave. Each request is a 32-bit word address, already relative to the start of the backing memory. The block keeps a small direct-mapped store of recently fetched lines. A request that finds its line present completes in a fixed number of cycles. A request that does not find it stalls the processor by holding waitrequest high. During the stall the block fetches the whole eight-word line over its memory-mapped master port, stores it, and then returns the requested word.

Any number of stall cycles the controller adds, and any gaps between its readdatavalid pulses, only lengthen the stall. The processor sees a single read in every case. There is no write path on either side.

Top module: `icache_bridge`

## Requirements
- R1: After reset every line is invalid, slave waitrequest is high, master read is low and slave readdata is zero. The first read of any address is therefore a miss.
- R2: slave waitrequest is high in the cycle the slave read is first asserted. It stays high until the requested word is ready.
- R3: On a hit, waitrequest goes low after the second rising clock edge at which read is seen high. readdata then carries the stored word.
- R4: A miss issues exactly eight master reads. The first goes to the requested word address with its three low bits cleared, and each later read goes to the previous address plus one.
- R5: While master waitrequest is high, master read and master address stay unchanged. The next address is presented only after a read has been accepted.
- R6: Returned words are written in arrival order at word offsets 0 to 7. After the eighth readdatavalid pulse, no further master read is issued for that miss.
- R7: A line becomes valid only once all eight words have arrived. After that, every word of the line is served as a hit.
- R8: After completion, and for as long as read stays high, waitrequest stays low and readdata stays stable.
- R9: After read has been low for one cycle, a new request is accepted. A hit that follows at once still takes the latency of R3.
- R10: The word address splits into word offset (bits 2:0), line index (bits 8:3) and tag (the remaining upper bits). A request whose tag differs from the tag held at its index misses and replaces that line.
- R11: A miss returns the correct memory word whatever stall and return delays the memory controller adds.
- R12: A hit issues no master read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| s_addr_i | input | ADDR_W | Slave word address |
| s_read_i | input | 1 | Slave read request |
| s_readdata_o | output | 32 | Slave read data |
| s_waitrequest_o | output | 1 | Slave stall, low when readdata is valid |
| m_addr_o | output | ADDR_W | Master word address |
| m_read_o | output | 1 | Master read request |
| m_readdata_i | input | 32 | Master read data |
| m_readdatavalid_i | input | 1 | Master read data valid |
| m_waitrequest_i | input | 1 | Master stall |

## Verification
The assertions rely on two assumptions about the inputs:
- The processor holds read and address steady until it sees waitrequest low.
- The memory controller returns exactly one readdatavalid per accepted read, in order, and never before that read has been accepted.

The bench memory model follows both rules. It records each accepted address, answers later in order and only from that record, and, in its slow phase, inserts random stalls and return gaps. The bench driver changes slave inputs only on falling edges, and only after the previous transfer has finished.

// File: rtl/icb_pkg.sv
package icb_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_FILL,
        ST_LOOK,
        ST_RESP
    } ctl_state_e;

    function automatic int unsigned width_of(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/icb_tag_store.sv
module icb_tag_store #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned TAG_W     = 11,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [TAG_W-1:0] rd_tag_o,
    output logic             rd_val_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i
);
    logic [TAG_W-1:0]     tags_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_valid
        always_ff @(posedge clk_i) begin
            if (rst_i)
                valid_q[g] <= 1'b0;
            else if (wr_en_i && wr_idx_i == IDX_W'(g))
                valid_q[g] <= 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_en_i)
            tags_q[wr_idx_i] <= wr_tag_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_val_o <= 1'b0;
            rd_tag_o <= '0;
        end else begin
            rd_val_o <= valid_q[rd_idx_i];
            rd_tag_o <= tags_q[rd_idx_i];
        end
    end
endmodule

// File: rtl/icb_data_store.sv
module icb_data_store import icb_pkg::*; #(
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic [AW-1:0] rd_addr_i,
    output word_t         rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  word_t         wr_data_i
);
    word_t mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i)
            mem_q[wr_addr_i] <= wr_data_i;
        rd_data_o <= mem_q[rd_addr_i];
    end
endmodule

// File: rtl/icb_refill.sv
module icb_refill import icb_pkg::*; #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LINE_WORDS = 8,
    localparam int unsigned OFF_W     = $clog2(LINE_WORDS),
    localparam int unsigned BASE_W    = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic              m_read_o,
    input  word_t             m_rdata_i,
    input  logic              m_rvalid_i,
    input  logic              m_wait_i,
    output logic              wr_en_o,
    output logic [OFF_W-1:0]  wr_off_o,
    output word_t             wr_data_o,
    output logic              done_o
);
    localparam logic [OFF_W:0] CNT_FULL = (OFF_W+1)'(LINE_WORDS);
    localparam logic [OFF_W:0] CNT_LAST = (OFF_W+1)'(LINE_WORDS - 1);

    logic              busy_q;
    logic [BASE_W-1:0] base_q;
    logic [OFF_W:0]    iss_q;
    logic [OFF_W:0]    rcv_q;
    logic              accept;

    assign m_read_o  = busy_q && (iss_q != CNT_FULL);
    assign m_addr_o  = {base_q, iss_q[OFF_W-1:0]};
    assign accept    = m_read_o && !m_wait_i;
    assign wr_en_o   = busy_q && m_rvalid_i;
    assign wr_off_o  = rcv_q[OFF_W-1:0];
    assign wr_data_o = m_rdata_i;
    assign done_o    = wr_en_o && (rcv_q == CNT_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q <= 1'b0;
            base_q <= '0;
            iss_q  <= '0;
            rcv_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            base_q <= base_i;
            iss_q  <= '0;
            rcv_q  <= '0;
        end else if (busy_q) begin
            if (accept)
                iss_q <= iss_q + 1'b1;
            if (wr_en_o)
                rcv_q <= rcv_q + 1'b1;
            if (done_o)
                busy_q <= 1'b0;
        end
    end

    // R4
    addr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && iss_q != CNT_LAST) |=> (m_read_o && m_addr_o == $past(m_addr_o) + 1'b1));

    // R5
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (m_read_o && m_wait_i) |=> (m_read_o && $stable(m_addr_o)));

    // R6
    no_read_after_fill_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !m_read_o);

    // R6
    data_after_issue_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_o |-> (rcv_q < iss_q));
endmodule

// File: rtl/icache_bridge.sv
module icache_bridge import icb_pkg::*; #(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned LINE_WORDS = 8,
    parameter int unsigned NUM_LINES  = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] s_addr_i,
    input  logic              s_read_i,
    output logic [31:0]       s_readdata_o,
    output logic              s_waitrequest_o,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic              m_read_o,
    input  logic [31:0]       m_readdata_i,
    input  logic              m_readdatavalid_i,
    input  logic              m_waitrequest_i
);
    localparam int unsigned OFF_W = $clog2(LINE_WORDS);
    localparam int unsigned IDX_W = $clog2(NUM_LINES);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned DEPTH = NUM_LINES * LINE_WORDS;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } waddr_t;

    ctl_state_e state_q;
    waddr_t     req_q;
    waddr_t     s_addr_w;
    word_t      rdata_q;

    logic [IDX_W-1:0] lk_idx;
    logic [OFF_W-1:0] lk_off;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_val;
    word_t            rd_word;
    logic             hit;

    logic             fill_start;
    logic             fill_wr;
    logic [OFF_W-1:0] fill_off;
    word_t            fill_data;
    logic             fill_done;

    assign s_addr_w = waddr_t'(s_addr_i);
    assign lk_idx   = (state_q == ST_IDLE) ? s_addr_w.idx : req_q.idx;
    assign lk_off   = (state_q == ST_IDLE) ? s_addr_w.off : req_q.off;
    assign hit      = rd_val && (rd_tag == req_q.tag);
    assign fill_start = (state_q == ST_CMP) && !hit;

    icb_tag_store #(
        .NUM_LINES(NUM_LINES),
        .TAG_W    (TAG_W)
    ) tags_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rd_idx_i(lk_idx),
        .rd_tag_o(rd_tag),
        .rd_val_o(rd_val),
        .wr_en_i (fill_done),
        .wr_idx_i(req_q.idx),
        .wr_tag_i(req_q.tag)
    );

    icb_data_store #(
        .DEPTH(DEPTH)
    ) data_i (
        .clk_i    (clk_i),
        .rd_addr_i({lk_idx, lk_off}),
        .rd_data_o(rd_word),
        .wr_en_i  (fill_wr),
        .wr_addr_i({req_q.idx, fill_off}),
        .wr_data_i(fill_data)
    );

    icb_refill #(
        .ADDR_W    (ADDR_W),
        .LINE_WORDS(LINE_WORDS)
    ) fill_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (fill_start),
        .base_i    ({req_q.tag, req_q.idx}),
        .m_addr_o  (m_addr_o),
        .m_read_o  (m_read_o),
        .m_rdata_i (m_readdata_i),
        .m_rvalid_i(m_readdatavalid_i),
        .m_wait_i  (m_waitrequest_i),
        .wr_en_o   (fill_wr),
        .wr_off_o  (fill_off),
        .wr_data_o (fill_data),
        .done_o    (fill_done)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (s_read_i) begin
                    req_q   <= s_addr_w;
                    state_q <= ST_CMP;
                end
                ST_CMP: if (hit) begin
                    rdata_q <= rd_word;
                    state_q <= ST_RESP;
                end else begin
                    state_q <= ST_FILL;
                end
                ST_FILL: if (fill_done) state_q <= ST_LOOK;
                ST_LOOK: state_q <= ST_CMP;
                ST_RESP: if (!s_read_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign s_waitrequest_o = (state_q != ST_RESP);
    assign s_readdata_o    = rdata_q;

    // R2
    rose_read_stalls_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(s_read_i) |-> s_waitrequest_o);

    // R3
    hit_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CMP && hit) |=> !s_waitrequest_o);

    // R8
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (s_read_i && !s_waitrequest_o) |=> (!s_read_i || (!s_waitrequest_o && $stable(s_readdata_o))));

    // R12
    no_fetch_on_hit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_CMP && hit) |=> !m_read_o);
endmodule

// File: tb/icache_bridge_tb_top.sv
module icache_bridge_tb_top;
    localparam int AW = 20;
    localparam int LW = 8;
    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] s_addr = '0;
    logic          s_read = 1'b0;
    logic [31:0]   s_rdata;
    logic          s_wait;
    logic [AW-1:0] m_addr;
    logic          m_read;
    logic [31:0]   m_rdata = '0;
    logic          m_rv = 1'b0;
    logic          m_wait = 1'b0;

    always #4 clk = ~clk;

    icache_bridge #(.ADDR_W(AW), .LINE_WORDS(LW), .NUM_LINES(NL)) dut_i (
        .clk_i(clk), .rst_i(rst),
        .s_addr_i(s_addr), .s_read_i(s_read), .s_readdata_o(s_rdata), .s_waitrequest_o(s_wait),
        .m_addr_o(m_addr), .m_read_o(m_read), .m_readdata_i(m_rdata),
        .m_readdatavalid_i(m_rv), .m_waitrequest_i(m_wait)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    function automatic logic [31:0] mem_word(logic [AW-1:0] a);
        return ({12'h0, a} * 32'h9E37_79B1) ^ 32'hC3A5_0F17;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // memory controller model
    logic [AW-1:0] pend_q[$];
    logic [AW-1:0] acc_log[$];
    logic [15:0]   lfsr = 16'hACE1;
    bit            slow = 0;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            m_rv = 0;
            m_wait = 0;
        end else begin
            if (pend_q.size() > 0 && (!slow || lfsr[0])) begin
                m_rv = 1;
                m_rdata = mem_word(pend_q.pop_front());
            end else begin
                m_rv = 0;
                m_rdata = 32'hDEAD_BEEF;
            end
            m_wait = slow ? lfsr[1] : 1'b0;
            if (m_read && !m_wait) begin
                pend_q.push_back(m_addr);
                acc_log.push_back(m_addr);
            end
        end
    end

    // scoreboard
    logic [31:0] exp_q[$];
    string       exp_req_q[$];
    bit          seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (s_wait) begin
                seen = 0;
            end else if (!seen) begin
                seen = 1;
                if (exp_q.size() == 0) begin
                    check(0, "R3", "unexpected completion", s_rdata, 32'h0);
                end else begin
                    logic [31:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = exp_req_q.pop_front();
                    check(s_rdata == e, r, "readdata", s_rdata, e);
                end
            end
        end
    end

    task automatic do_read(logic [AW-1:0] a, bit exp_miss, int hold, string req);
        int cyc = 0;
        logic [AW-1:0] base;
        base = {a[AW-1:3], 3'b000};
        acc_log.delete();
        exp_q.push_back(mem_word(a));
        exp_req_q.push_back(req);
        s_addr = a;
        s_read = 1;
        #1;
        check(s_wait == 1'b1, "R2", "waitrequest at request", 32'(s_wait), 32'd1);
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!s_wait || cyc > 5000) break;
            if (cyc == 1) check(1'b1, "R2", "stall", 32'(s_wait), 32'd1);
        end
        if (exp_miss)
            check(cyc > 2, "R1", "miss latency", 32'(cyc), 32'd3);
        else
            check(cyc == 2, "R3", "hit latency", 32'(cyc), 32'd2);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(s_wait == 1'b0, "R8", "waitrequest held low", 32'(s_wait), 32'd0);
            check(s_rdata == mem_word(a), "R8", "readdata held", s_rdata, mem_word(a));
        end
        s_read = 0;
        @(negedge clk);
        if (exp_miss) begin
            check(acc_log.size() == LW, "R4", "reads per miss", 32'(acc_log.size()), 32'(LW));
            for (int k = 0; k < LW && k < acc_log.size(); k++)
                check(acc_log[k] == base + AW'(k), slow ? "R5" : "R4", "fill address",
                      32'(acc_log[k]), 32'(base + AW'(k)));
        end else begin
            check(acc_log.size() == 0, "R12", "master reads on hit", 32'(acc_log.size()), 32'd0);
        end
        check(m_read == 1'b0, "R6", "master idle after transfer", 32'(m_read), 32'd0);
    endtask

    function automatic logic [AW-1:0] mk_addr(int tag, int idx, int off);
        return AW'((tag << 9) | (idx << 3) | off);
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        check(s_wait == 1'b1, "R1", "reset waitrequest", 32'(s_wait), 32'd1);
        check(m_read == 1'b0, "R1", "reset master read", 32'(m_read), 32'd0);
        check(s_rdata == 32'h0, "R1", "reset readdata", s_rdata, 32'h0);
        @(negedge clk);

        // R1 first access misses, R3 then hits
        do_read(mk_addr(9, 6, 4), 1, 0, "R1");
        do_read(mk_addr(9, 6, 4), 0, 0, "R3");
        // R7: every word of the filled line hits
        for (int k = 0; k < LW; k++)
            do_read(mk_addr(9, 6, k), 0, 0, "R7");
        // R10: conflicting tag at same index evicts
        do_read(mk_addr(300, 6, 1), 1, 0, "R10");
        do_read(mk_addr(9, 6, 4), 1, 0, "R10");
        do_read(mk_addr(300, 6, 1), 1, 0, "R10");
        do_read(mk_addr(300, 6, 7), 0, 0, "R10");
        // R8 hold, then R9 back-to-back
        do_read(mk_addr(300, 6, 2), 0, 3, "R8");
        do_read(mk_addr(300, 6, 3), 0, 0, "R9");
        do_read(mk_addr(300, 6, 0), 0, 2, "R9");
        // R11/R5: slow controller with random stalls and gaps
        slow = 1;
        for (int i = 0; i < 12; i++) begin
            do_read(mk_addr(i + 5, 10 + i, i % LW), 1, 0, "R11");
            do_read(mk_addr(i + 5, 10 + i, (i + 3) % LW), 0, 0, "R11");
        end
        slow = 0;
        // boundaries: lowest and highest word addresses
        do_read('0, 1, 0, "R11");
        do_read('0, 0, 0, "R11");
        do_read('1, 1, 0, "R11");
        do_read('1, 0, 1, "R11");
        do_read(AW'('1) - AW'(7), 0, 0, "R7");
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R3", "pending expectations", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule